// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. At every rising clock edge it looks at two active-low address strobes (one from a processor, one from a cache controller), an active-low advance input, three chip enables and an external address. A strobe taken while the enables select the device loads the external address and opens a burst. Later cycles with both strobes high either step the burst or hold it, depending on the advance input.

Only the low bits of the address are sequenced. The upper bits keep the loaded value for the whole burst. A static order input chooses one of two step orders. One counts upward and wraps. The other is the start offset XOR a burst count. Beside the address the block keeps a registered selected flag that the data path uses to drive or float its outputs. The array, the data path and the write decoding are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and right after it, `selected` is 0 and `word_addr` is all zeros.
- R2: If `ads_ctl_n` is low at an edge while `ce_main_n` is low, `ce_hi` is high and `ce_lo_n` is low, then from that edge on `word_addr` equals the sampled `addr_in` and `selected` is 1.
- R3: The processor strobe `ads_cpu_n` sampled low with `ce_main_n` low starts a burst in the same way, provided `ce_hi` is high and `ce_lo_n` is low.
- R4: While `ce_main_n` is high, a low `ads_cpu_n` is ignored. The edge acts as a continue or suspend cycle, so `selected` and the loaded address do not change.
- R5: If a strobe is taken while the three enables do not all select (from either strobe, including the controller strobe with `ce_main_n` high), then `selected` goes to 0 after that edge and `word_addr` keeps its value.
- R6: `ce_hi` and `ce_lo_n` have no effect on edges where no strobe is taken. A burst in progress keeps `selected` at 1 and keeps stepping.
- R7: With `order_sel` = 0 (linear), each edge with both strobes high and `adv_n` low while selected adds 1 to the low two bits of `word_addr`, modulo 4.
- R8: With `order_sel` = 1 (interleaved), the low two bits after k advances are the start low bits XOR (k mod 4). A start of 01 gives 01, 00, 11, 10.
- R9: An edge with both strobes high and `adv_n` high leaves `word_addr` unchanged (suspend).
- R10: During a burst the upper 15 bits of `word_addr` stay at their loaded value. After four advances the low bits are back at the start value and the sequence carries on without stopping.
- R11: While `selected` is 0 and no strobe is taken, `adv_n` low leaves `word_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_cpu_n | input | 1 | Processor address strobe, active low, blocked while `ce_main_n` is high |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Second chip enable, active high, looked at only on strobe edges |
| ce_lo_n | input | 1 | Third chip enable, active low, looked at only on strobe edges |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | 17 | External start address |
| word_addr | output | 17 | Current array word address |
| selected | output | 1 | Registered selected flag |

## Verification
The assertions check every cycle that a qualified strobe loads the address and sets the flag, that a disqualified strobe clears the flag and keeps the address, and that a blocked processor strobe leaves the flag alone. They also check that suspend and deselected cycles hold the address, that the upper bits hold between strobes, and that the linear order adds one to the low bits on each advance. The interleaved order, the return to the start after four advances, and the proof that the second and third enables are ignored in the middle of a burst all depend on a whole sequence of cycles. Only the bench's directed scenarios show these, by comparing each address with one computed from the start value.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_cpu_n,
  input  logic              ads_ctl_n,
  input  logic              adv_n,
  input  logic              ce_main_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected
);
  localparam int HI_W = ADDR_W - STEP_W;

  logic [HI_W-1:0]   hi_q;
  logic [STEP_W-1:0] start_lo_q;
  logic [STEP_W-1:0] cnt_q;
  logic              sel_q;
  logic [STEP_W-1:0] lo;

  wire cpu_go     = !ads_cpu_n && !ce_main_n;
  wire any_strobe = cpu_go || !ads_ctl_n;
  wire enables_ok = !ce_main_n && ce_hi && !ce_lo_n;
  wire load       = any_strobe && enables_ok;
  wire step       = !any_strobe && sel_q && !adv_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      start_lo_q <= '0;
      cnt_q      <= '0;
      sel_q      <= 1'b0;
    end else begin
      if (any_strobe) sel_q <= enables_ok;
      if (load) begin
        hi_q       <= addr_in[ADDR_W-1:STEP_W];
        start_lo_q <= addr_in[STEP_W-1:0];
        cnt_q      <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lo        = order_sel ? (start_lo_q ^ cnt_q) : (start_lo_q + cnt_q);
  assign word_addr = {hi_q, lo};
  assign selected  = sel_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!selected && word_addr == '0));

  assert_ctl_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctl_n && !ce_main_n && ce_hi && !ce_lo_n)
      |=> (selected && word_addr == $past(addr_in)));

  assert_cpu_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_cpu_n && !ce_main_n && ce_hi && !ce_lo_n)
      |=> (selected && word_addr == $past(addr_in)));

  assert_cpu_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_cpu_n && ce_main_n && ads_ctl_n) |=> $stable(selected));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ads_ctl_n || (!ads_cpu_n && !ce_main_n)) && !(!ce_main_n && ce_hi && !ce_lo_n))
      |=> (!selected && $stable(word_addr)));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && ads_ctl_n && (ads_cpu_n || ce_main_n) && !adv_n && !order_sel)
      |=> (order_sel ||
           word_addr[STEP_W-1:0] == STEP_W'($past(word_addr[STEP_W-1:0]) + 1'b1)));

  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctl_n && (ads_cpu_n || ce_main_n) && adv_n)
      |=> ($stable(selected) && (word_addr == $past(word_addr) || $changed(order_sel))));

  assert_upper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctl_n && (ads_cpu_n || ce_main_n))
      |=> $stable(word_addr[ADDR_W-1:STEP_W]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && ads_ctl_n && (ads_cpu_n || ce_main_n))
      |=> (!selected && (word_addr == $past(word_addr) || $changed(order_sel))));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_cpu_n = 1'b1, ads_ctl_n = 1'b1, adv_n = 1'b1;
  logic        ce_main_n = 1'b1, ce_hi = 1'b0, ce_lo_n = 1'b1;
  logic        order_sel = 1'b0;
  logic [16:0] addr_in = '0;
  logic [16:0] word_addr;
  logic        selected;

  int checks = 0;
  int errors = 0;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
    .adv_n(adv_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .order_sel(order_sel), .addr_in(addr_in), .word_addr(word_addr),
    .selected(selected)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; adv_n = 1'b1;
    ce_main_n = 1'b1; ce_hi = 1'b0; ce_lo_n = 1'b1;
  endtask

  task automatic start_ctl(input logic [16:0] a);
    addr_in = a; ads_ctl_n = 1'b0; ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    step();
    idle();
  endtask

  task automatic t_reset();
    chk(!selected, "R1 selected", 17'(selected), 17'd0);
    chk(word_addr == '0, "R1 addr", word_addr, 17'd0);
  endtask

  task automatic t_linear();
    logic [16:0] a = 17'h1ABC5;
    order_sel = 1'b0;
    start_ctl(a);
    chk(selected, "R2 selected", 17'(selected), 17'd1);
    chk(word_addr == a, "R2 addr", word_addr, a);
    adv_n = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      logic [16:0] e = {a[16:2], 2'(a[1:0] + k)};
      step();
      chk(word_addr == e, k == 4 ? "R10 wrap linear" : "R7 linear", word_addr, e);
    end
    adv_n = 1'b1;
  endtask

  task automatic t_interleave();
    logic [16:0] a = 17'h0F0F1;
    logic [1:0] seq [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    order_sel = 1'b1;
    addr_in = a; ads_cpu_n = 1'b0; ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    step();
    idle();
    chk(selected && word_addr == a, "R3 cpu start", word_addr, a);
    adv_n = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      logic [16:0] e = {a[16:2], seq[k % 4]};
      step();
      chk(word_addr == e, "R8 interleave", word_addr, e);
      chk(word_addr[16:2] == a[16:2], "R10 upper", word_addr, a);
    end
    adv_n = 1'b1;
    order_sel = 1'b0;
  endtask

  task automatic t_suspend_and_enables();
    logic [16:0] a = 17'h00102;
    start_ctl(a);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(word_addr == a, "R9 suspend", word_addr, a);
    end
    adv_n = 1'b0; ce_hi = 1'b0; ce_lo_n = 1'b1;
    step();
    chk(selected, "R6 selected kept", 17'(selected), 17'd1);
    chk(word_addr == 17'h00103, "R6 still steps", word_addr, 17'h00103);
    idle();
  endtask

  task automatic t_cpu_blocked();
    logic [16:0] a = 17'h12340;
    start_ctl(a);
    addr_in = 17'h0AAAB; ads_cpu_n = 1'b0; ce_main_n = 1'b1; ce_hi = 1'b1; ce_lo_n = 1'b0;
    step();
    idle();
    chk(selected, "R4 flag", 17'(selected), 17'd1);
    chk(word_addr == a, "R4 addr", word_addr, a);
  endtask

  task automatic t_deselect();
    logic [16:0] a = 17'h05556;
    start_ctl(a);
    addr_in = 17'h1FFFF; ads_ctl_n = 1'b0; ce_main_n = 1'b1; ce_hi = 1'b1; ce_lo_n = 1'b0;
    step();
    idle();
    chk(!selected, "R5 ctl deselect", 17'(selected), 17'd0);
    chk(word_addr == a, "R5 addr held", word_addr, a);
    adv_n = 1'b0;
    step(); step();
    chk(word_addr == a, "R11 no step", word_addr, a);
    chk(!selected, "R11 flag", 17'(selected), 17'd0);
    idle();
    start_ctl(a);
    addr_in = 17'h00001; ads_cpu_n = 1'b0; ce_main_n = 1'b0; ce_hi = 1'b0; ce_lo_n = 1'b0;
    step();
    idle();
    chk(!selected, "R5 cpu deselect", 17'(selected), 17'd0);
    chk(word_addr == a, "R5 cpu addr held", word_addr, a);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_linear();
    t_interleave();
    t_suspend_and_enables();
    t_cpu_blocked();
    t_deselect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule